// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers interrupt events from eighteen sources spread over sixteen priority levels and tells the processor which level to service next. Each source has a pending flag that a one-cycle event pulse sets. Each level maps to a one-word vector slot near the top of the address space. The controller drives a request line, the winning level and that level's vector address. All three outputs are combinational from the registered flags, the enable bits and the global enable taken from the processor status word.

Sources fall into three masking classes. Source 17 sits alone on level 15 and is the reset class: no enable can block it. Sources 14, 15 and 16 share level 14 (oscillator fault, flash access violation, external NMI). Each of them has its own enable bit and none of them looks at the global enable. Sources 0 to 13 are maskable, one per level 0 to 13, and each needs both its own enable and the global enable. A configuration input decides whether the external reset pin feeds the reset class or the external-NMI flag.

When the processor takes an interrupt it pulses the acknowledge input together with the level it is servicing. Single-source levels then clear their flags. Multi-source levels keep their flags so that the service routine can find the cause and clear it through the software clear input.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every pending flag and every enable bit is zero, so `irq_req` is low, `irq_lvl` is 0 and `irq_vec` is 0xFFE0.
- R2: `irq_vec` equals 0xFFE0 plus twice `irq_lvl`. Level 15 gives 0xFFFE and level 13 gives 0xFFFA.
- R3: A pending source 17 raises a level-15 request whatever the state of `gie` and of every enable bit.
- R4: A pending source 14, 15 or 16 raises a level-14 request only while its own enable bit is set. `gie` has no effect on these sources.
- R5: A pending maskable source n (0 to 13) raises a level-n request only while its enable bit and `gie` are both set.
- R6: When several levels are allowed, the highest-numbered one wins and the flags of the lower levels stay pending.
- R7: A cycle with `ack` high clears every flag on level `ack_lvl` if that level has a single source. It clears nothing if the level has several sources. By default the multi-source levels are 1, 4, 5, 9, 12, 14 and 15.
- R8: An event pulse on a source in the same cycle as an acknowledge or software clear of that source leaves its flag set.
- R9: A pulse on `ext_rst_evt` sets the source-16 flag when `ext_rst_nmi` is 1 and the source-17 flag when it is 0.
- R10: A write with `en_we` high loads the enables by byte. Address 0 loads sources 0 to 7 from bits 7:0. Address 1 loads sources 8 to 13 from bits 5:0. Address 2 loads sources 14 to 16 from bits 2:0. Address 3 changes nothing.
- R11: A high bit n of `src_clr` clears the flag of source n on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 18 | One-cycle event pulses, one per source |
| src_clr | input | 18 | Software clear strobes, one per source |
| ext_rst_evt | input | 1 | External reset pin event pulse |
| ext_rst_nmi | input | 1 | 1 sends the external reset to source 16, 0 sends it to source 17 |
| gie | input | 1 | Global interrupt enable from the status word |
| en_we | input | 1 | Enable register write strobe |
| en_addr | input | 2 | Enable register byte select |
| en_wdata | input | 8 | Enable register write data |
| ack | input | 1 | Acknowledge strobe |
| ack_lvl | input | 4 | Level being acknowledged |
| irq_req | output | 1 | Interrupt request |
| irq_lvl | output | 4 | Winning level |
| irq_vec | output | 16 | Vector address of the winning level |

## Verification
The bench attacks the masking classes one by one. It shows that turning off `gie` drops a maskable request but leaves an enabled level-14 source and the reset source in place. A design that applied the global enable to every class would lose the NMI or the reset request here. It acknowledges multi-source levels and checks that their flags survive, which catches a controller that clears every acknowledged level. It also acknowledges a level in the same cycle as a new event on that level, which exposes a design that lets the clear win. The external reset routing is tested in both settings, and so is the unused enable address.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_LVL  = 16;
  localparam int LVL_W    = $clog2(NUM_LVL);
  localparam int N_MASK   = 14;
  localparam int N_NMI    = 3;
  localparam int N_EN     = N_MASK + N_NMI;
  localparam int N_SRC    = N_EN + 1;
  localparam int SRC_RST  = N_SRC - 1;
  localparam int SRC_XNMI = N_EN - 1;
  localparam int LVL_NMI  = NUM_LVL - 2;
  localparam int LVL_RST  = NUM_LVL - 1;
  localparam int VEC_W    = 16;

  // Priority level that a source belongs to.
  function automatic logic [LVL_W-1:0] lvl_of(input int src);
    if (src < N_MASK)      return LVL_W'(src);
    else if (src < N_EN)   return LVL_W'(LVL_NMI);
    else                   return LVL_W'(LVL_RST);
  endfunction

  // One word per level above the base address.
  function automatic logic [VEC_W-1:0] vec_of(input logic [VEC_W-1:0] base,
                                              input logic [LVL_W-1:0] lvl);
    return base + {{(VEC_W-LVL_W-1){1'b0}}, lvl, 1'b0};
  endfunction
endpackage

// File: rtl/irqc_enables.sv
module irqc_enables
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_we,
  input  logic [1:0]      en_addr,
  input  logic [7:0]      en_wdata,
  output logic [N_EN-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      case (en_addr)
        2'd0:    en_q[7:0]           <= en_wdata;
        2'd1:    en_q[N_MASK-1:8]    <= en_wdata[N_MASK-9:0];
        2'd2:    en_q[N_EN-1:N_MASK] <= en_wdata[N_NMI-1:0];
        default: en_q                <= en_q;
      endcase
    end
  end
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags
  import irqc_pkg::*;
#(
  parameter logic [NUM_LVL-1:0] MULTI_LVL = 16'hD232
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_vec,
  input  logic [N_SRC-1:0] src_clr,
  input  logic             ack,
  input  logic [LVL_W-1:0] ack_lvl,
  output logic [N_SRC-1:0] clr_vec,
  output logic [N_SRC-1:0] flag_q
);
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    localparam logic [LVL_W-1:0] MY_LVL = lvl_of(s);
    logic ack_hit;
    assign ack_hit    = ack && (ack_lvl == MY_LVL) && !MULTI_LVL[MY_LVL];
    assign clr_vec[s] = src_clr[s] | ack_hit;

    always_ff @(posedge clk) begin
      if (!rst_n) flag_q[s] <= 1'b0;
      else        flag_q[s] <= set_vec[s] | (flag_q[s] & ~clr_vec[s]);
    end
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic [N_SRC-1:0]   flag_q,
  input  logic [N_EN-1:0]    en_q,
  input  logic               gie,
  output logic [NUM_LVL-1:0] lvl_ok,
  output logic               req,
  output logic [LVL_W-1:0]   lvl
);
  logic [N_SRC-1:0] src_ok;

  for (genvar s = 0; s < N_SRC; s++) begin : g_ok
    if (s < N_MASK) begin : g_mask
      assign src_ok[s] = flag_q[s] & en_q[s] & gie;
    end else if (s < N_EN) begin : g_nmi
      assign src_ok[s] = flag_q[s] & en_q[s];
    end else begin : g_rst
      assign src_ok[s] = flag_q[s];
    end
  end

  always_comb begin
    lvl_ok = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (src_ok[s]) lvl_ok[lvl_of(s)] = 1'b1;
    end
  end

  always_comb begin
    req = |lvl_ok;
    lvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (lvl_ok[l]) lvl = LVL_W'(l);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter logic [VEC_W-1:0]   VEC_BASE  = 16'hFFE0,
  parameter logic [NUM_LVL-1:0] MULTI_LVL = 16'hD232
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_evt,
  input  logic [N_SRC-1:0] src_clr,
  input  logic             ext_rst_evt,
  input  logic             ext_rst_nmi,
  input  logic             gie,
  input  logic             en_we,
  input  logic [1:0]       en_addr,
  input  logic [7:0]       en_wdata,
  input  logic             ack,
  input  logic [LVL_W-1:0] ack_lvl,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_lvl,
  output logic [VEC_W-1:0] irq_vec
);
  logic [N_SRC-1:0]   set_vec;
  logic [N_SRC-1:0]   clr_vec;
  logic [N_SRC-1:0]   flag_q;
  logic [N_EN-1:0]    en_q;
  logic [NUM_LVL-1:0] lvl_ok;

  always_comb begin
    set_vec = src_evt;
    if (ext_rst_evt) begin
      if (ext_rst_nmi) set_vec[SRC_XNMI] = 1'b1;
      else             set_vec[SRC_RST]  = 1'b1;
    end
  end

  irqc_enables u_en (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_addr(en_addr),
    .en_wdata(en_wdata), .en_q(en_q)
  );

  irqc_flags #(.MULTI_LVL(MULTI_LVL)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .src_clr(src_clr),
    .ack(ack), .ack_lvl(ack_lvl), .clr_vec(clr_vec), .flag_q(flag_q)
  );

  irqc_arbiter u_arb (
    .flag_q(flag_q), .en_q(en_q), .gie(gie), .lvl_ok(lvl_ok),
    .req(irq_req), .lvl(irq_lvl)
  );

  assign irq_vec = vec_of(VEC_BASE, irq_lvl);
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irqc_pkg::*;
#(
  parameter logic [NUM_LVL-1:0] MULTI_LVL = 16'hD232
) (
  input logic               clk,
  input logic               rst_n,
  input logic               gie,
  input logic               ack,
  input logic [LVL_W-1:0]   ack_lvl,
  input logic               irq_req,
  input logic [LVL_W-1:0]   irq_lvl,
  input logic [N_SRC-1:0]   set_vec,
  input logic [N_SRC-1:0]   flag_q,
  input logic [N_EN-1:0]    en_q,
  input logic [NUM_LVL-1:0] lvl_ok
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !irq_req);

  a_r3_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q[SRC_RST] |-> (irq_req && irq_lvl == LVL_W'(LVL_RST)));

  a_r4_nmi_own_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_lvl == LVL_W'(LVL_NMI)) |-> |(flag_q[N_EN-1:N_MASK] & en_q[N_EN-1:N_MASK]));

  a_r5_mask_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_lvl < LVL_W'(LVL_NMI)) |-> gie);

  a_r6_winner_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (lvl_ok[irq_lvl] && $onehot0(lvl_ok >> irq_lvl)));

  a_r7_ack_clears_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_lvl < LVL_W'(N_MASK) && !MULTI_LVL[ack_lvl] && !set_vec[ack_lvl])
      |=> !flag_q[$past(ack_lvl)]);

  a_r8_set_not_lost: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((flag_q & $past(set_vec)) == $past(set_vec)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.MULTI_LVL(MULTI_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .ack(ack), .ack_lvl(ack_lvl),
  .irq_req(irq_req), .irq_lvl(irq_lvl), .set_vec(set_vec),
  .flag_q(flag_q), .en_q(en_q), .lvl_ok(lvl_ok)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] src_evt = '0;
  logic [17:0] src_clr = '0;
  logic        ext_rst_evt = 1'b0;
  logic        ext_rst_nmi = 1'b0;
  logic        gie = 1'b0;
  logic        en_we = 1'b0;
  logic [1:0]  en_addr = '0;
  logic [7:0]  en_wdata = '0;
  logic        ack = 1'b0;
  logic [3:0]  ack_lvl = '0;
  logic        irq_req;
  logic [3:0]  irq_lvl;
  logic [15:0] irq_vec;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_clr(src_clr),
    .ext_rst_evt(ext_rst_evt), .ext_rst_nmi(ext_rst_nmi), .gie(gie),
    .en_we(en_we), .en_addr(en_addr), .en_wdata(en_wdata), .ack(ack),
    .ack_lvl(ack_lvl), .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_vec(irq_vec)
  );

  // Behavioural reference model.
  bit m_pend[18];
  bit m_en[17];

  function automatic int ref_lvl(int s);
    if (s <= 13) return s;
    if (s <= 16) return 14;
    return 15;
  endfunction

  function automatic bit ref_multi(int l);
    return (l == 1) || (l == 4) || (l == 5) || (l == 9) || (l == 12) || (l == 14) || (l == 15);
  endfunction

  function automatic bit ref_fire(int s);
    if (s == 17) return m_pend[s];
    if (s >= 14) return m_pend[s] && m_en[s];
    return m_pend[s] && m_en[s] && gie;
  endfunction

  function automatic int ref_win();
    int best = -1;
    for (int s = 0; s < 18; s++)
      if (ref_fire(s) && ref_lvl(s) > best) best = ref_lvl(s);
    return best;
  endfunction

  always @(posedge clk) begin
    bit nxt[18];
    if (!rst_n) begin
      foreach (m_pend[i]) m_pend[i] = 0;
      foreach (m_en[i]) m_en[i] = 0;
    end else begin
      for (int s = 0; s < 18; s++) begin
        bit setb, clrb;
        setb = src_evt[s];
        if (ext_rst_evt && ((s == 16 && ext_rst_nmi) || (s == 17 && !ext_rst_nmi))) setb = 1;
        clrb = src_clr[s] || (ack && int'(ack_lvl) == ref_lvl(s) && !ref_multi(ref_lvl(s)));
        nxt[s] = setb || (m_pend[s] && !clrb);
      end
      if (en_we) begin
        if (en_addr == 0) for (int b = 0; b < 8; b++) m_en[b] = en_wdata[b];
        if (en_addr == 1) for (int b = 0; b < 6; b++) m_en[8 + b] = en_wdata[b];
        if (en_addr == 2) for (int b = 0; b < 3; b++) m_en[14 + b] = en_wdata[b];
      end
      foreach (m_pend[i]) m_pend[i] = nxt[i];
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int w;
      int el;
      w = ref_win();
      el = (w < 0) ? 0 : w;
      n_chk++;
      if (irq_req !== (w >= 0) || irq_lvl !== el[3:0] || irq_vec !== 16'hFFE0 + 16'(2 * el)) begin
        n_err++;
        $display("FAIL R6 model: req=%0b lvl=%0d vec=%h expected req=%0b lvl=%0d vec=%h",
                 irq_req, irq_lvl, irq_vec, (w >= 0), el, 16'hFFE0 + 16'(2 * el));
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    src_evt = '0; src_clr = '0; ext_rst_evt = 0; en_we = 0; ack = 0;
  endtask

  task automatic wr_en(input logic [1:0] a, input logic [7:0] d);
    en_we = 1; en_addr = a; en_wdata = d;
    tick();
  endtask

  task automatic expect_out(input string tag, input bit req, input int lvl);
    @(negedge clk);
    n_chk++;
    if (irq_req !== req || (req && (irq_lvl !== lvl[3:0] || irq_vec !== 16'hFFE0 + 16'(2 * lvl)))) begin
      n_err++;
      $display("FAIL %s: req=%0b lvl=%0d vec=%h expected req=%0b lvl=%0d vec=%h",
               tag, irq_req, irq_lvl, irq_vec, req, lvl, 16'hFFE0 + 16'(2 * lvl));
    end
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    @(negedge clk);
    n_chk++;
    if (irq_req !== 0 || irq_lvl !== 0 || irq_vec !== 16'hFFE0) begin
      n_err++;
      $display("FAIL R1: req=%0b lvl=%0d vec=%h expected req=0 lvl=0 vec=ffe0", irq_req, irq_lvl, irq_vec);
    end
    tick();
    gie = 1;
    src_evt[3] = 1; tick();
    expect_out("R1 enables cleared", 0, 0);
    wr_en(2'd0, 8'h08);
    expect_out("R5 R10 R2 level 3", 1, 3);
    gie = 0; tick();
    expect_out("R5 gie off", 0, 0);
    src_evt[14] = 1; tick();
    expect_out("R4 nmi without enable", 0, 0);
    wr_en(2'd2, 8'h01);
    expect_out("R4 nmi ignores gie", 1, 14);
    src_evt[17] = 1; tick();
    expect_out("R3 reset wins", 1, 15);
    ack = 1; ack_lvl = 4'd15; tick();
    expect_out("R7 multi level 15 kept", 1, 15);
    src_clr[17] = 1; tick();
    expect_out("R11 clear reset flag", 1, 14);
    ack = 1; ack_lvl = 4'd14; tick();
    expect_out("R7 multi level 14 kept", 1, 14);
    src_clr[14] = 1; gie = 1; tick();
    expect_out("R11 R6 lower pending", 1, 3);
    wr_en(2'd1, 8'h01);
    src_evt[8] = 1; tick();
    expect_out("R6 R10 level 8 wins", 1, 8);
    ack = 1; ack_lvl = 4'd8; tick();
    expect_out("R7 single level 8 cleared", 1, 3);
    wr_en(2'd3, 8'hFF);
    expect_out("R10 address 3 ignored", 1, 3);
    ack = 1; ack_lvl = 4'd3; src_evt[3] = 1; tick();
    expect_out("R8 set beats ack", 1, 3);
    src_clr[3] = 1; src_evt[3] = 1; tick();
    expect_out("R8 set beats clear", 1, 3);
    ack = 1; ack_lvl = 4'd3; tick();
    expect_out("R7 single level 3 cleared", 0, 0);
    wr_en(2'd0, 8'h10);
    src_evt[4] = 1; tick();
    ack = 1; ack_lvl = 4'd4; tick();
    expect_out("R7 multi level 4 kept", 1, 4);
    src_clr[4] = 1; tick();
    expect_out("R11 clear level 4", 0, 0);
    wr_en(2'd2, 8'h04);
    ext_rst_nmi = 1; ext_rst_evt = 1; tick();
    expect_out("R9 ext reset as nmi", 1, 14);
    src_clr[16] = 1; tick();
    expect_out("R9 reset class untouched", 0, 0);
    ext_rst_nmi = 0; ext_rst_evt = 1; tick();
    expect_out("R9 R2 ext reset to level 15", 1, 15);
    src_clr[17] = 1; tick();
    wr_en(2'd1, 8'h20);
    src_evt[13] = 1; tick();
    expect_out("R2 level 13 vector", 1, 13);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule